// File: doc/BRIEF.md
# Debug Scan Module Selector

This block is the command front end of a scan-based debug unit. It sits behind one user data register of the test access port and sees the port's serial input together with its shift, capture and update strobes. Each scan ends in an update. At that point the block looks at the most significant bit of the scanned word. That bit decides what the scan was for:

- When the bit is 1, the scan was a select command. The bits just below it name one of the downstream debug modules.
- When the bit is 0, the scan was meant for the module that is already selected. That module is left to act on it.

The selection is held in a small register and persists across any number of later scans. While the selection is valid, the block steers the shift, capture and update strobes to the selected module only. It returns that module's serial output on TDO. With the default parameters, the modules are numbered as follows:

- 0: system-bus access
- 1: first processor control
- 2: second processor control
- 3: serial console port

The command bits are shifted in least significant bit first. Each new bit enters at the top of an internal shift register. Whatever scan length was used, the bit that is most significant at Update-DR therefore always sits in the top position. This lets a 3-bit select scan and a long module scan share one register.

Top module: `dbg_module_selector`

## Requirements
- R1: Asynchronous reset (rst_ni low) and a synchronous test-logic-reset (tlr_i high at a rising tck_i edge) both set the selection to module 0 and clear sel_valid_o. While sel_valid_o is 0, every per-module strobe is 0.
- R2: An update (update_i and dbg_ir_i high at a rising edge) whose flag bit is 1 loads the module number into sel_o and sets sel_valid_o from the next cycle on. The flag bit is the last bit shifted in. The module number is the SEL_W bits shifted in just before the flag, so the final bit before the flag is the module number's MSB.
- R3: An update whose flag bit is 0 leaves sel_o and sel_valid_o unchanged.
- R4: The selection holds across any number of later scans of any length from 3 to CMD_W bits, until a select command arrives.
- R5: mod_shift_o and mod_capture_o are one-hot-or-zero. Bit m follows shift_i or capture_i in the same cycle only when dbg_ir_i is 1, sel_valid_o is 1 and sel_o equals m.
- R6: During an update whose flag bit is 0, mod_update_o carries the update to the selected module only, and only while sel_valid_o is 1. During a select update, every bit of mod_update_o is 0.
- R7: tdo_o equals mod_tdo_i[sel_o] while sel_valid_o is 1, and is 0 while sel_valid_o is 0.
- R8: While dbg_ir_i is 0, strobes are ignored: no module strobe is raised and the selection does not change.
- R9: mod_tdi_o forwards tdi_i to all modules unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tlr_i | input | 1 | Test-logic-reset state, synchronous |
| dbg_ir_i | input | 1 | Debug user instruction is loaded |
| tdi_i | input | 1 | Serial data in |
| shift_i | input | 1 | Shift-DR strobe |
| capture_i | input | 1 | Capture-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| mod_tdo_i | input | NUM_MODS | Serial outputs of the modules |
| mod_tdi_o | output | 1 | Serial data to the modules |
| mod_shift_o | output | NUM_MODS | Gated shift strobe per module |
| mod_capture_o | output | NUM_MODS | Gated capture strobe per module |
| mod_update_o | output | NUM_MODS | Gated update strobe per module |
| tdo_o | output | 1 | Serial data out |
| sel_o | output | SEL_W | Selected module number |
| sel_valid_o | output | 1 | A select command has completed since reset |

## Verification
The strobe gates, the TDI fan-out and the TDO mux are combinational, so each of their results is due in the same cycle as the input. The bench drives each input on the falling edge and samples these outputs 2 ns later. The selection register takes a select command at the rising edge that ends the update cycle. The bench therefore checks sel_o and sel_valid_o at the following falling edge, one register stage after the update. For each update cycle, the expected strobe values come from the selection as it stood before that edge.

// File: rtl/dbg_sel_pkg.sv
package dbg_sel_pkg;
  localparam int unsigned DBG_NUM_MODS = 4;
  localparam int unsigned DBG_CMD_W    = 53;

  typedef enum logic [1:0] {
    MOD_SYSBUS = 2'd0,
    MOD_CPU_A  = 2'd1,
    MOD_CPU_B  = 2'd2,
    MOD_CONSOLE = 2'd3
  } dbg_mod_e;
endpackage

// File: rtl/dbg_cmd_shreg.sv
// LSB-first command shifter: new bits enter at the top, so the last bit
// shifted (the command MSB) is always at CMD_W-1 on Update-DR.
module dbg_cmd_shreg #(
  parameter int unsigned CMD_W = 53,
  parameter int unsigned SEL_W = 2
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             tdi_i,
  output logic             flag_o,
  output logic [SEL_W-1:0] mod_o
);
  localparam int unsigned FLAG_POS = CMD_W - 1;
  localparam int unsigned MOD_TOP  = CMD_W - 2;

  logic [CMD_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= {tdi_i, sr_q[CMD_W-1:1]};
  end

  assign flag_o = sr_q[FLAG_POS];
  assign mod_o  = sr_q[MOD_TOP -: SEL_W];
endmodule

// File: rtl/dbg_sel_reg.sv
module dbg_sel_reg #(
  parameter int unsigned NUM_MODS = 4,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tlr_i,
  input  logic             load_i,
  input  logic [SEL_W-1:0] mod_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             valid_o
);
  logic in_range;

  generate
    if (NUM_MODS == (1 << SEL_W)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      assign in_range = (32'(mod_i) < NUM_MODS);
    end
  endgenerate

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      valid_o <= 1'b0;
    end else if (tlr_i) begin
      sel_o   <= '0;
      valid_o <= 1'b0;
    end else if (load_i && in_range) begin
      sel_o   <= mod_i;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_strobe_gate.sv
module dbg_strobe_gate #(
  parameter int unsigned NUM_MODS = 4,
  parameter int unsigned SEL_W    = 2
) (
  input  logic                dbg_ir_i,
  input  logic                valid_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                flag_i,
  input  logic                shift_i,
  input  logic                capture_i,
  input  logic                update_i,
  input  logic [NUM_MODS-1:0] mod_tdo_i,
  output logic [NUM_MODS-1:0] shift_o,
  output logic [NUM_MODS-1:0] capture_o,
  output logic [NUM_MODS-1:0] update_o,
  output logic                tdo_o
);
  logic live;
  logic [NUM_MODS-1:0] hit;
  logic [NUM_MODS-1:0] tdo_pick;

  assign live = dbg_ir_i && valid_i;

  generate
    for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
      assign hit[m]       = live && (sel_i == SEL_W'(m));
      assign shift_o[m]   = hit[m] && shift_i;
      assign capture_o[m] = hit[m] && capture_i;
      // a select update belongs to this block, not to any module
      assign update_o[m]  = hit[m] && update_i && !flag_i;
      assign tdo_pick[m]  = valid_i && (sel_i == SEL_W'(m)) && mod_tdo_i[m];
    end
  endgenerate

  assign tdo_o = |tdo_pick;
endmodule

// File: rtl/dbg_module_selector.sv
module dbg_module_selector
  import dbg_sel_pkg::*;
#(
  parameter int unsigned NUM_MODS = DBG_NUM_MODS,
  parameter int unsigned CMD_W    = DBG_CMD_W,
  parameter int unsigned SEL_W    = $clog2(NUM_MODS)
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                tlr_i,
  input  logic                dbg_ir_i,
  input  logic                tdi_i,
  input  logic                shift_i,
  input  logic                capture_i,
  input  logic                update_i,
  input  logic [NUM_MODS-1:0] mod_tdo_i,
  output logic                mod_tdi_o,
  output logic [NUM_MODS-1:0] mod_shift_o,
  output logic [NUM_MODS-1:0] mod_capture_o,
  output logic [NUM_MODS-1:0] mod_update_o,
  output logic                tdo_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic                sel_valid_o
);
  logic             cmd_flag;
  logic [SEL_W-1:0] cmd_mod;
  logic             shift_en;
  logic             sel_load;

  assign shift_en  = dbg_ir_i && shift_i && !tlr_i;
  assign sel_load  = dbg_ir_i && update_i && cmd_flag;
  assign mod_tdi_o = tdi_i;

  dbg_cmd_shreg #(.CMD_W(CMD_W), .SEL_W(SEL_W)) u_shreg (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .tdi_i      (tdi_i),
    .flag_o     (cmd_flag),
    .mod_o      (cmd_mod)
  );

  dbg_sel_reg #(.NUM_MODS(NUM_MODS), .SEL_W(SEL_W)) u_sel (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tlr_i   (tlr_i),
    .load_i  (sel_load),
    .mod_i   (cmd_mod),
    .sel_o   (sel_o),
    .valid_o (sel_valid_o)
  );

  dbg_strobe_gate #(.NUM_MODS(NUM_MODS), .SEL_W(SEL_W)) u_gate (
    .dbg_ir_i  (dbg_ir_i),
    .valid_i   (sel_valid_o),
    .sel_i     (sel_o),
    .flag_i    (cmd_flag),
    .shift_i   (shift_i),
    .capture_i (capture_i),
    .update_i  (update_i),
    .mod_tdo_i (mod_tdo_i),
    .shift_o   (mod_shift_o),
    .capture_o (mod_capture_o),
    .update_o  (mod_update_o),
    .tdo_o     (tdo_o)
  );
endmodule

// File: rtl/dbg_module_selector_chk.sv
module dbg_module_selector_chk #(
  parameter int unsigned NUM_MODS = 4,
  parameter int unsigned SEL_W    = 2
) (
  input logic                tck_i,
  input logic                rst_ni,
  input logic                tlr_i,
  input logic                dbg_ir_i,
  input logic                shift_i,
  input logic                capture_i,
  input logic                update_i,
  input logic [NUM_MODS-1:0] mod_shift_o,
  input logic [NUM_MODS-1:0] mod_capture_o,
  input logic [NUM_MODS-1:0] mod_update_o,
  input logic                tdo_o,
  input logic [SEL_W-1:0]    sel_o,
  input logic                sel_valid_o,
  input logic                flag_i,
  input logic [SEL_W-1:0]    mod_i
);
  assert_tlr_clears_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (!sel_valid_o && sel_o == '0));

  assert_invalid_quiet_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_valid_o |-> (mod_shift_o == '0 && mod_capture_o == '0 && mod_update_o == '0));

  assert_select_loads_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (dbg_ir_i && update_i && flag_i && !tlr_i) |=> (sel_valid_o && sel_o == $past(mod_i)));

  assert_passthru_keeps_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (dbg_ir_i && update_i && !flag_i && !tlr_i) |=> ($stable(sel_o) && $stable(sel_valid_o)));

  assert_shift_onehot_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0(mod_shift_o) && $onehot0(mod_capture_o) && $onehot0(mod_update_o));

  assert_shift_needs_strobe_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mod_shift_o != '0) |-> (shift_i && dbg_ir_i));

  assert_select_update_hidden_R6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    flag_i |-> (mod_update_o == '0));

  assert_tdo_idle_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_valid_o |-> !tdo_o);

  assert_ir_off_hold_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!dbg_ir_i && !tlr_i) |=> ($stable(sel_o) && $stable(sel_valid_o)));

  assert_ir_off_quiet_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !dbg_ir_i |-> (mod_shift_o == '0 && mod_capture_o == '0 && mod_update_o == '0));
endmodule

bind dbg_module_selector dbg_module_selector_chk #(.NUM_MODS(NUM_MODS), .SEL_W(SEL_W)) u_chk (
  .tck_i         (tck_i),
  .rst_ni        (rst_ni),
  .tlr_i         (tlr_i),
  .dbg_ir_i      (dbg_ir_i),
  .shift_i       (shift_i),
  .capture_i     (capture_i),
  .update_i      (update_i),
  .mod_shift_o   (mod_shift_o),
  .mod_capture_o (mod_capture_o),
  .mod_update_o  (mod_update_o),
  .tdo_o         (tdo_o),
  .sel_o         (sel_o),
  .sel_valid_o   (sel_valid_o),
  .flag_i        (cmd_flag),
  .mod_i         (cmd_mod)
);

// File: tb/tb_dbg_module_selector.sv
module tb_dbg_module_selector;
  localparam int NM = 4;
  localparam int SW = 2;
  localparam int CW = 53;

  logic tck = 1'b0;
  always #10 tck = ~tck;

  logic rst_n, tlr, dbg_ir, tdi, shift, capture, update;
  logic [NM-1:0] mod_tdo, mod_shift, mod_capture, mod_update;
  logic mod_tdi, tdo, sel_valid;
  logic [SW-1:0] sel;

  dbg_module_selector #(.NUM_MODS(NM), .CMD_W(CW)) dut (
    .tck_i(tck), .rst_ni(rst_n), .tlr_i(tlr), .dbg_ir_i(dbg_ir), .tdi_i(tdi),
    .shift_i(shift), .capture_i(capture), .update_i(update), .mod_tdo_i(mod_tdo),
    .mod_tdi_o(mod_tdi), .mod_shift_o(mod_shift), .mod_capture_o(mod_capture),
    .mod_update_o(mod_update), .tdo_o(tdo), .sel_o(sel), .sel_valid_o(sel_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [SW-1:0] exp_sel = '0;
  logic exp_valid = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NM-1:0] gate(input bit on);
    logic [NM-1:0] v = '0;
    if (on && exp_valid) v[exp_sel] = 1'b1;
    return v;
  endfunction

  function automatic logic exp_tdo(input logic [NM-1:0] t);
    return exp_valid ? t[exp_sel] : 1'b0;
  endfunction

  // one scan: capture, len shift cycles LSB first, update; drive at negedge
  task automatic scan(input logic [63:0] bits, input int len, input bit ir);
    logic flag;
    dbg_ir = ir;
    capture = 1'b1;
    #2 chk("R5 capture gate", 64'(mod_capture), 64'(gate(ir)));
    @(negedge tck) capture = 1'b0;
    for (int i = 0; i < len; i++) begin
      shift = 1'b1;
      tdi = bits[i];
      mod_tdo = NM'($urandom);
      #2;
      chk("R5 shift gate", 64'(mod_shift), 64'(gate(ir)));
      chk("R7 tdo mux", 64'(tdo), 64'(exp_tdo(mod_tdo)));
      chk("R9 tdi fanout", 64'(mod_tdi), 64'(tdi));
      @(negedge tck);
    end
    shift = 1'b0;
    update = 1'b1;
    flag = bits[len-1];
    #2 chk("R6 update gate", 64'(mod_update), 64'(flag ? '0 : gate(ir)));
    @(negedge tck) update = 1'b0;
    if (ir && flag) begin
      exp_sel = {bits[len-2], bits[len-3]};
      exp_valid = 1'b1;
    end
    #2;
    chk(flag ? "R2 select loads" : "R3/R4/R8 selection held", 64'(sel), 64'(exp_sel));
    chk("R2 valid", 64'(sel_valid), 64'(exp_valid));
    @(negedge tck);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tlr = 1'b0; dbg_ir = 1'b1; tdi = 1'b0;
    shift = 1'b1; capture = 1'b0; update = 1'b0; mod_tdo = '1;
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge tck);
    #2;
    chk("R1 reset sel", 64'(sel), 0);
    chk("R1 reset valid", 64'(sel_valid), 0);
    chk("R1 reset shift gate", 64'(mod_shift), 0);
    chk("R7 tdo idle", 64'(tdo), 0);
    @(negedge tck) rst_n = 1'b1; shift = 1'b0;

    // directed corner cases
    scan(64'b110, 3, 1'b1);                       // select 2
    scan(64'h0ff, 10, 1'b1);                      // module scan, held
    scan(64'b100, 3, 1'b1);                       // select 0
    scan(64'h3ff, 12, 1'b1);                      // module scan
    scan((64'b1 << 52) | (64'b01 << 50), CW, 1'b1); // full-width select 1
    scan(64'b111, 3, 1'b0);                       // ignored, ir off
    scan(64'b111, 3, 1'b1);                       // select 3
    tlr = 1'b1;
    @(negedge tck) tlr = 1'b0;
    exp_sel = '0; exp_valid = 1'b0;
    #2;
    chk("R1 tlr sel", 64'(sel), 0);
    chk("R1 tlr valid", 64'(sel_valid), 0);
    @(negedge tck);
    scan(64'h055, 9, 1'b1);                       // module scan while invalid

    for (int k = 0; k < 300; k++) begin
      logic [63:0] b;
      int len;
      b = {$urandom, $urandom};
      len = 3 + int'($urandom_range(0, CW - 3));
      scan(b, len, ($urandom_range(0, 7) != 0));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule